// File: doc/BRIEF.md
# Display Controller Register and Interrupt Bank

This block is the software-visible register file of a display controller. A processor reaches it over a simple synchronous bus: an address, a write strobe and 32-bit write data, with read data returned combinationally from the presented address. It holds the panel control words, frame-buffer start addresses, colour lookup words, a dither word, a temporary palette word, three interrupt registers, a port select word and a palette window of 16-bit entries.

The bank decodes the fields the rest of the controller needs and drives them out as dedicated signals: display enable, pixel depth code, palette format, swap mode, and the panel width and height. Pixel fetch and panel timing are not part of this block. A single-cycle frame-done strobe stands in for them and raises the frame-sync interrupt source. Pending interrupts accumulate from the unmasked sources, and one registered interrupt line reports whether any is pending.

Top module: `lcd_regbank`

## Requirements
- R1: After reset, every control, address, lookup, dither, temporary palette, interrupt and port select register reads zero, all decoded outputs are zero except panel width and height (both 1), and irq is low.
- R2: A write keeps only bits 17:0 of control word 1 (0x00), bits 15:0 of control word 4 (0x0C), bits 12:0 of control word 5 (0x10), bits 1:0 of interrupt pending (0x54) and source (0x58), and bits 2:0 of the interrupt mask (0x5C); control words 2 and 3 (0x04, 0x08), the start addresses (0x14, 0x18, 0x1C), the red, green and blue lookups (0x20, 0x24, 0x28), dither (0x4C) and temporary palette (0x50) keep all 32 bits; the masked-off bits read zero.
- R3: A write to the port select register (0x60) stores write data bits 1:0 and always sets bit 2, so it reads back as 4 + (data & 3).
- R4: disp_en is control word 1 bit 0, pix_depth is control word 1 bits 4:1, pal_565 is control word 5 bit 11 and swap_mode is control word 5 bit 12.
- R5: panel_h equals control word 2 bits 23:14 plus one, and panel_w equals control word 3 bits 18:8 plus one.
- R6: Addresses 0x400 to 0x5FF select palette entry (address - 0x400) >> 1; a write stores data bits 15:0 and a read returns the entry zero-extended, from either byte address of the entry.
- R7: Any other address reads zero, and a write to it changes no register.
- R8: On every cycle pending becomes (written pending value, or the held value) OR (new source AND NOT the low two bits of the new mask); pending bits are never dropped except by a write to pending.
- R9: A frame-done pulse sets source bit 1, on top of any value written to the source register in the same cycle.
- R10: irq is registered: it goes high one cycle after any pending bit is set and low one cycle after pending becomes zero.
- R11: Writes to pending and source overwrite them; software clears a pending bit by first clearing or masking its source and then writing pending without that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| frame_done | input | 1 | One-cycle end-of-frame strobe |
| irq | output | 1 | Interrupt request, high while any pending bit is set |
| disp_en | output | 1 | Display enable |
| pix_depth | output | 4 | Pixel depth code |
| pal_565 | output | 1 | Palette entries in 5:6:5 format |
| swap_mode | output | 1 | Byte/halfword swap selected |
| panel_w | output | 12 | Panel width in pixels |
| panel_h | output | 11 | Panel height in lines |

## Verification
On every cycle the assertions check that pending always covers the unmasked sources, that pending bits survive any cycle without a pending write, that a frame-done pulse lands in source bit 1, that irq tracks pending with one cycle of delay, that the port select bit 2 sticks after a write, that control word 1 never shows bits above 17, and that the panel height is never zero. Write masks for every register, the full palette sweep with both byte addresses of each entry, the pixel depth codes, the panel size extremes, the silence of unmapped addresses and the clearing sequence for a pending interrupt are shown only by the bench's scenarios.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int DATA_W     = 32;
  localparam int NUM_WORDS  = 13;
  localparam int WIDX_W     = 4;
  localparam int SRC_W      = 2;
  localparam int MASK_W     = 3;
  localparam int PSEL_W     = 3;
  localparam int FRAME_BIT  = 1;

  // byte offsets whose positions software depends on
  localparam int unsigned OFF_LAST_LINEAR = 'h28;
  localparam int unsigned OFF_DITH        = 'h4C;
  localparam int unsigned OFF_TPAL        = 'h50;
  localparam int unsigned OFF_PEND        = 'h54;
  localparam int unsigned OFF_SRC         = 'h58;
  localparam int unsigned OFF_MASK        = 'h5C;
  localparam int unsigned OFF_PSEL        = 'h60;
  localparam int unsigned PAL_BASE        = 'h400;

  // word slots in the general store
  localparam int W_CTL1 = 0;
  localparam int W_CTL2 = 1;
  localparam int W_CTL3 = 2;
  localparam int W_CTL4 = 3;
  localparam int W_CTL5 = 4;
  localparam int W_DITH = 11;
  localparam int W_TPAL = 12;

  typedef struct packed {
    logic              word_hit;
    logic [WIDX_W-1:0] word_idx;
    logic              pend_hit;
    logic              src_hit;
    logic              mask_hit;
    logic              psel_hit;
    logic              pal_hit;
  } lcd_dec_t;

  // bits retained on write for each general word
  function automatic logic [DATA_W-1:0] word_keep(input int idx);
    case (idx)
      W_CTL1:  word_keep = 32'h0003_FFFF;
      W_CTL4:  word_keep = 32'h0000_FFFF;
      W_CTL5:  word_keep = 32'h0000_1FFF;
      default: word_keep = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAL_DEPTH = 256,
  localparam int PIDX_W   = $clog2(PAL_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output lcd_dec_t          dec,
  output logic [PIDX_W-1:0] pal_idx
);

  localparam int unsigned PAL_END = PAL_BASE + 2 * PAL_DEPTH;

  logic [31:0] a32;
  logic        aligned;
  logic [31:0] pal_off;

  always_comb begin
    a32     = 32'(addr);
    aligned = (a32[1:0] == 2'b00);
    pal_off = a32 - PAL_BASE;
    pal_idx = pal_off[PIDX_W:1];

    dec          = '0;
    dec.pal_hit  = (a32 >= PAL_BASE) && (a32 < PAL_END);
    dec.pend_hit = (a32 == OFF_PEND);
    dec.src_hit  = (a32 == OFF_SRC);
    dec.mask_hit = (a32 == OFF_MASK);
    dec.psel_hit = (a32 == OFF_PSEL);
    if (aligned && (a32 <= OFF_LAST_LINEAR)) begin
      dec.word_hit = 1'b1;
      dec.word_idx = a32[WIDX_W+1:2];
    end else if (a32 == OFF_DITH) begin
      dec.word_hit = 1'b1;
      dec.word_idx = WIDX_W'(W_DITH);
    end else if (a32 == OFF_TPAL) begin
      dec.word_hit = 1'b1;
      dec.word_idx = WIDX_W'(W_TPAL);
    end
  end

endmodule

// File: rtl/lcd_word_store.sv
module lcd_word_store
  import lcd_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  lcd_dec_t          dec,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] words [NUM_WORDS],
  output logic [PSEL_W-1:0] psel
);

  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              psel_en;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] KEEP = word_keep(gi);
    logic [DATA_W-1:0] q, d;
    logic              en;

    always_comb begin
      en = wr && dec.word_hit && (dec.word_idx == WIDX_W'(gi));
      d  = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign words[gi] = q;
  end

  always_comb begin
    psel_en = wr && dec.psel_hit;
    psel_d  = {1'b1, wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psel_q <= '0;
    else if (psel_en) psel_q <= psel_d;
  end

  assign psel = psel_q;

endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pend,
  input  logic              wr_src,
  input  logic              wr_mask,
  input  logic [MASK_W-1:0] wbits,
  input  logic              frame_done,
  output logic [SRC_W-1:0]  pend,
  output logic [SRC_W-1:0]  src,
  output logic [MASK_W-1:0] mask,
  output logic              irq
);

  logic [SRC_W-1:0]  pend_q, pend_d, pend_base;
  logic [SRC_W-1:0]  src_q, src_d, src_base, frame_bits;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              irq_q, irq_d;

  always_comb begin
    frame_bits            = '0;
    frame_bits[FRAME_BIT] = frame_done;
    src_base  = wr_src  ? wbits[SRC_W-1:0] : src_q;
    src_d     = src_base | frame_bits;
    mask_d    = wr_mask ? wbits : mask_q;
    pend_base = wr_pend ? wbits[SRC_W-1:0] : pend_q;
    pend_d    = pend_base | (src_d & ~mask_d[SRC_W-1:0]);
    irq_d     = |pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      src_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign pend = pend_q;
  assign src  = src_q;
  assign mask = mask_q;
  assign irq  = irq_q;

endmodule

// File: rtl/lcd_palette_ram.sv
module lcd_palette_ram #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAL_DEPTH = 256,
  parameter int PAL_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_done,
  output logic              irq,
  output logic              disp_en,
  output logic [3:0]        pix_depth,
  output logic              pal_565,
  output logic              swap_mode,
  output logic [11:0]       panel_w,
  output logic [10:0]       panel_h
);

  localparam int PIDX_W = $clog2(PAL_DEPTH);

  lcd_dec_t          dec;
  logic [PIDX_W-1:0] pal_idx;
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [PSEL_W-1:0] psel_w;
  logic [SRC_W-1:0]  pend_w, src_w;
  logic [MASK_W-1:0] mask_w;
  logic [PAL_W-1:0]  pal_rd;
  logic              pal_we;

  lcd_addr_decode #(.ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH)) u_dec (
    .addr    (bus_addr),
    .dec     (dec),
    .pal_idx (pal_idx)
  );

  lcd_word_store u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .dec   (dec),
    .wdata (bus_wdata),
    .words (words),
    .psel  (psel_w)
  );

  lcd_irq_unit u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_pend    (bus_wr && dec.pend_hit),
    .wr_src     (bus_wr && dec.src_hit),
    .wr_mask    (bus_wr && dec.mask_hit),
    .wbits      (bus_wdata[MASK_W-1:0]),
    .frame_done (frame_done),
    .pend       (pend_w),
    .src        (src_w),
    .mask       (mask_w),
    .irq        (irq)
  );

  assign pal_we = bus_wr && dec.pal_hit;

  lcd_palette_ram #(.DEPTH(PAL_DEPTH), .WIDTH(PAL_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .idx   (pal_idx),
    .wdata (bus_wdata[PAL_W-1:0]),
    .rdata (pal_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (dec.word_hit)      bus_rdata = words[dec.word_idx];
    else if (dec.pend_hit) bus_rdata = 32'(pend_w);
    else if (dec.src_hit)  bus_rdata = 32'(src_w);
    else if (dec.mask_hit) bus_rdata = 32'(mask_w);
    else if (dec.psel_hit) bus_rdata = 32'(psel_w);
    else if (dec.pal_hit)  bus_rdata = 32'(pal_rd);
  end

  always_comb begin
    disp_en   = words[W_CTL1][0];
    pix_depth = words[W_CTL1][4:1];
    pal_565   = words[W_CTL5][11];
    swap_mode = words[W_CTL5][12];
    panel_h   = {1'b0, words[W_CTL2][23:14]} + 11'd1;
    panel_w   = {1'b0, words[W_CTL3][18:8]} + 12'd1;
  end

endmodule

// File: rtl/lcd_regbank_chk.sv
module lcd_regbank_chk
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              frame_done,
  input logic              irq,
  input logic [10:0]       panel_h,
  input logic [SRC_W-1:0]  pend,
  input logic [SRC_W-1:0]  src,
  input logic [MASK_W-1:0] mask,
  input logic [PSEL_W-1:0] psel
);

  logic pend_wr, psel_wr;
  assign pend_wr = bus_wr && (32'(bus_addr) == OFF_PEND);
  assign psel_wr = bus_wr && (32'(bus_addr) == OFF_PSEL);

  AST_PEND_COVERS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & src & ~mask[SRC_W-1:0]) == (src & ~mask[SRC_W-1:0]))); // R8

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend & $past(pend)) == $past(pend))); // R8

  AST_FRAME_SETS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> src[FRAME_BIT]); // R9

  AST_IRQ_LAGS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(pend) != '0))); // R10

  AST_PSEL_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
    psel_wr |=> psel[2]); // R3

  AST_CTL1_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr) == 32'h0) |-> (bus_rdata[31:18] == '0)); // R2

  AST_PANEL_H_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    panel_h != '0); // R5

endmodule

bind lcd_regbank lcd_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .frame_done (frame_done),
  .irq        (irq),
  .panel_h    (panel_h),
  .pend       (pend_w),
  .src        (src_w),
  .mask       (mask_w),
  .psel       (psel_w)
);

// File: tb/tb_lcd_regbank.sv
module tb_lcd_regbank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        frame_done;
  logic        irq, disp_en, pal_565, swap_mode;
  logic [3:0]  pix_depth;
  logic [11:0] panel_w;
  logic [10:0] panel_h;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lcd_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .irq(irq), .disp_en(disp_en), .pix_depth(pix_depth), .pal_565(pal_565),
    .swap_mode(swap_mode), .panel_w(panel_w), .panel_h(panel_h)
  );

  // linear word offsets and the bits each keeps (R2)
  function automatic logic [11:0] word_off(input int i);
    if (i <= 10)      return 12'(i * 4);
    else if (i == 11) return 12'h04C;
    else              return 12'h050;
  endfunction

  function automatic logic [31:0] word_keep_exp(input int i);
    if (i == 0)      return 32'h0003_FFFF;
    else if (i == 3) return 32'h0000_FFFF;
    else if (i == 4) return 32'h0000_1FFF;
    else             return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic frame_pulse(input logic [11:0] a, input logic [31:0] d, input bit with_wr);
    @(negedge clk);
    frame_done = 1'b1;
    bus_addr = a; bus_wdata = d; bus_wr = with_wr;
    @(negedge clk);
    frame_done = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; frame_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    for (int i = 0; i < 13; i++) begin
      rd(word_off(i), v); chk("R1 word reset", v, 32'h0);
    end
    rd(12'h054, v); chk("R1 pend reset", v, 0);
    rd(12'h058, v); chk("R1 src reset", v, 0);
    rd(12'h05C, v); chk("R1 mask reset", v, 0);
    rd(12'h060, v); chk("R1 psel reset", v, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 outputs reset", {disp_en, pix_depth, pal_565, swap_mode}, 0);
    chk("R1 width reset", 32'(panel_w), 1);
    chk("R1 height reset", 32'(panel_h), 1);

    // R2: write masks with two patterns per word
    for (int i = 0; i < 13; i++) begin
      for (int p = 0; p < 2; p++) begin
        pat = (p == 0) ? 32'hFFFF_FFFF : (32'hA5C3_5A3C ^ 32'(i * 32'h0101_0101));
        wr(word_off(i), pat);
        rd(word_off(i), v);
        chk("R2 word mask", v, pat & word_keep_exp(i));
      end
    end
    wr(12'h05C, 32'hFFFF_FFF8); rd(12'h05C, v); chk("R2 mask width", v, 0);
    wr(12'h05C, 32'hFFFF_FFFF); rd(12'h05C, v); chk("R2 mask width", v, 7);
    wr(12'h058, 32'hFFFF_FFFD); rd(12'h058, v); chk("R2 src width", v, 1);
    wr(12'h054, 32'hFFFF_FFFE); rd(12'h054, v); chk("R2 pend width", v, 2);
    wr(12'h058, 0); wr(12'h054, 0); wr(12'h05C, 0);

    // R3: port select sweep
    for (int d = 0; d < 8; d++) begin
      wr(12'h060, 32'hFFFF_FFF0 | 32'(d));
      rd(12'h060, v); chk("R3 psel", v, 32'd4 + 32'(d & 3));
    end

    // R4: decoded fields over every depth code
    for (int c = 0; c < 32; c++) begin
      wr(12'h000, 32'hFFFC_0000 | 32'(c));
      chk("R4 enable", 32'(disp_en), 32'(c & 1));
      chk("R4 depth", 32'(pix_depth), 32'(c >> 1));
    end
    for (int c = 0; c < 4; c++) begin
      wr(12'h010, 32'(c) << 11);
      chk("R4 palette format", 32'(pal_565), 32'(c & 1));
      chk("R4 swap", 32'(swap_mode), 32'(c >> 1));
    end

    // R5: panel size extremes and a middle value
    foreach (pat[k]) begin
      if (k < 3) begin
        int h = (k == 0) ? 0 : (k == 1) ? 1023 : 479;
        int w = (k == 0) ? 0 : (k == 1) ? 2047 : 639;
        wr(12'h004, (32'(h) << 14) | 32'hFF00_3FFF);
        wr(12'h008, (32'(w) << 8)  | 32'hFFF8_00FF);
        chk("R5 height", 32'(panel_h), 32'(h + 1));
        chk("R5 width", 32'(panel_w), 32'(w + 1));
      end
    end

    // R6: full palette sweep, upper data bits discarded
    for (int e = 0; e < 256; e++)
      wr(12'(32'h400 + 2 * e), 32'hDEAD_0000 | ((32'(e) * 32'h0107) ^ 32'h0000_A5C3));
    for (int e = 0; e < 256; e++) begin
      pat = ((32'(e) * 32'h0107) ^ 32'h0000_A5C3) & 32'h0000_FFFF;
      rd(12'(32'h400 + 2 * e), v);     chk("R6 palette even", v, pat);
      rd(12'(32'h400 + 2 * e + 1), v); chk("R6 palette odd", v, pat);
    end

    // R7: unmapped addresses read zero and leave state alone
    wr(12'h014, 32'h1234_5678);
    for (int u = 0; u < 6; u++) begin
      logic [11:0] ua;
      ua = (u == 0) ? 12'h02C : (u == 1) ? 12'h030 : (u == 2) ? 12'h064 :
           (u == 3) ? 12'h3FE : (u == 4) ? 12'h600 : 12'h015;
      wr(ua, 32'hFFFF_FFFF);
      rd(ua, v); chk("R7 unmapped read", v, 0);
    end
    rd(12'h014, v); chk("R7 neighbour intact", v, 32'h1234_5678);
    rd(12'h400, v); chk("R7 palette intact", v, 32'h0000_A5C3);
    rd(12'h5FE, v); chk("R7 palette last intact", v, ((32'd255 * 32'h0107) ^ 32'h0000_A5C3) & 32'hFFFF);
    rd(12'h054, v); chk("R7 pend intact", v, 0);

    // R8/R9: masked frame source does not pend
    wr(12'h05C, 32'h3);
    frame_pulse(12'h000, 0, 1'b0);
    rd(12'h058, v); chk("R9 frame sets src1", v, 2);
    rd(12'h054, v); chk("R8 masked no pend", v, 0);
    tick(); chk("R10 irq low while masked", 32'(irq), 0);

    // R8/R10: unmasking pends, irq one cycle later
    wr(12'h05C, 0);
    rd(12'h054, v); chk("R8 unmask pends", v, 2);
    chk("R10 irq not yet", 32'(irq), 0);
    tick(); chk("R10 irq after one cycle", 32'(irq), 1);

    // R11: clearing pend while source live re-pends
    wr(12'h054, 0);
    rd(12'h054, v); chk("R11 live src re-pends", v, 2);
    wr(12'h058, 0); wr(12'h054, 0);
    rd(12'h054, v); chk("R11 cleared pend", v, 0);
    chk("R10 irq still high", 32'(irq), 1);
    tick(); chk("R10 irq drops", 32'(irq), 0);

    // R9: frame pulse together with a source write of bit 0
    frame_pulse(12'h058, 32'h1, 1'b1);
    rd(12'h058, v); chk("R9 frame ORs with write", v, 3);
    rd(12'h054, v); chk("R8 both pend", v, 3);

    // R11/R8: mask bit 0, clear pend, bit 1 re-pends, bit 0 stays clear
    wr(12'h05C, 32'h1);
    wr(12'h054, 0);
    rd(12'h054, v); chk("R8 partial mask", v, 2);
    rd(12'h058, v); chk("R11 src unchanged by pend write", v, 3);
    wr(12'h058, 32'h1); wr(12'h054, 0);
    rd(12'h054, v); chk("R11 clear sequence", v, 0);
    tick(); tick(); chk("R10 irq low at end", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule